// File: doc/BRIEF.md
# Change-of-Flow Bubble Sequencer with Single-Entry Return Cache

This block steers instruction fetch when a five-stage pipeline, two of whose stages access memory, meets a change of flow. Decode hands it one event per cycle: a kind code, the resolved condition, a delayed flag, the PC of the current execution set, the PC of the next set, an immediate field, and a return value read from the slower stack path. The block works out the new fetch address and how many bubble cycles the pipeline must absorb. It raises a one-cycle redirect strobe carrying that address and flushes younger fetched sets while the bubbles last.

A single return-address register holds the most recent call's return point. A return that finds this register valid is redirected from it at the short penalty. A return that finds it empty takes its target from the stack input and costs one more bubble. A delayed form keeps one already-fetched execution set alive in the first slot, so that cycle does the work of a bubble. The penalty then drops by one.

The controller is a three-state machine. IDLE accepts events. REDIRECT is the first bubble cycle, in which the strobe fires. DRAIN covers the remaining bubble cycles. The transitions are: IDLE to REDIRECT on a taken event (accept); REDIRECT to DRAIN when more than one bubble remains (continue); REDIRECT to IDLE when it was the only bubble (finish-short); DRAIN to DRAIN while bubbles remain (continue); and DRAIN to IDLE on the last bubble (finish).

Top module: `cof_sequencer`

## Requirements
- R1: After reset, `issue_bubble`, `flush_younger`, `fetch_redirect` and `slot_keep` are 0, and the return register is empty, so the first return takes the stack path.
- R2: Kind code 0 (jump with immediate target) redirects to `evt_imm` and inserts 2 bubble cycles.
- R3: Kind code 1 (PC-relative jump) redirects to `evt_pc + evt_imm`, taken modulo 2^AW, and inserts 3 bubble cycles.
- R4: Kind code 2 (conditional branch) with `evt_cond`=1 redirects to `evt_pc + evt_imm` and inserts 3 bubble cycles.
- R5: Kind code 2 with `evt_cond`=0 produces no redirect, no bubble and no flush, whatever the delayed flag says.
- R6: Kind code 3 (call) redirects to `evt_imm`, inserts 2 bubble cycles, and stores `evt_next_pc` in the return register, marking it valid.
- R7: Kind code 4 (return) with a valid return register redirects to the stored address, inserts 2 bubble cycles, and empties the register.
- R8: Kind code 4 with an empty return register redirects to `stack_ret` and inserts 3 bubble cycles.
- R9: With `evt_delayed`=1, a taken event inserts one bubble fewer than its normal count, and `slot_keep` is 1 in exactly the first bubble cycle. With `evt_delayed`=0, `slot_keep` stays 0.
- R10: The first bubble cycle is the cycle right after the event is sampled. `fetch_redirect` is high only in that cycle. `flush_younger` equals `issue_bubble` in every cycle. `fetch_target` holds steady through the bubbles.
- R11: Events presented while bubbles are in progress are ignored: they neither lengthen the bubble run nor touch the return register.
- R12: A second call overwrites the return register, so a later return goes to the newer address.
- R13: Kind codes 5 to 7 are ignored: no redirect, no bubble, and no change to the return register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | A change-of-flow event is present this cycle |
| evt_kind | input | 3 | Kind code: 0 immediate jump, 1 PC-relative, 2 conditional, 3 call, 4 return |
| evt_cond | input | 1 | Resolved condition of a conditional branch |
| evt_delayed | input | 1 | Event is a delayed form |
| evt_pc | input | AW | PC of the execution set holding the event |
| evt_next_pc | input | AW | PC of the following execution set (return point of a call) |
| evt_imm | input | AW | Immediate target or PC-relative offset |
| stack_ret | input | AW | Return address from the slow stack path |
| fetch_redirect | output | 1 | One-cycle strobe: restart fetch at `fetch_target` |
| fetch_target | output | AW | New fetch address |
| issue_bubble | output | 1 | A bubble cycle is being inserted |
| flush_younger | output | 1 | Discard younger fetched sets, except a kept delay-slot set |
| slot_keep | output | 1 | The delay-slot set is kept for execution |

## Verification
Every result is registered once behind the sampling edge. The redirect strobe, target, first flush and `slot_keep` are therefore due one cycle after the event, and the bubble run then lasts the stated count of whole cycles. The bench drives each event on a falling edge and removes it on the next falling edge. It then samples on each falling edge, counting bubble cycles until `issue_bubble` drops, and checks the redirect, slot and flush values cycle by cycle within that run. A sweep over all eight kind codes, both condition values and both delayed settings is checked against a bench-side model of the return register. Directed sequences then cover the return-register hits, overwrites and events sent during bubbles.

// File: rtl/cof_pkg.sv
package cof_pkg;
    typedef enum logic [2:0] {
        COF_JMP_IMM = 3'd0,
        COF_JMP_REL = 3'd1,
        COF_BR_COND = 3'd2,
        COF_CALL    = 3'd3,
        COF_RET     = 3'd4
    } cof_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE     = 2'd0,
        SQ_REDIRECT = 2'd1,
        SQ_DRAIN    = 2'd2
    } seq_state_e;
endpackage

// File: rtl/cof_target_unit.sv
module cof_target_unit #(
    parameter int AW             = 32,
    parameter int PEN_IMM        = 2,
    parameter int PEN_REL        = 3,
    parameter int PEN_MISS_EXTRA = 1,
    parameter int CW             = 3
) (
    input  logic [2:0]    kind,
    input  logic          cond,
    input  logic          delayed,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] imm,
    input  logic [AW-1:0] stack_ret,
    input  logic          rc_valid,
    input  logic [AW-1:0] rc_addr,
    output logic          taken,
    output logic          is_call,
    output logic          is_ret,
    output logic [AW-1:0] target,
    output logic [CW-1:0] penalty
);
    import cof_pkg::*;

    localparam logic [CW-1:0] P_IMM  = CW'(PEN_IMM);
    localparam logic [CW-1:0] P_REL  = CW'(PEN_REL);
    localparam logic [CW-1:0] P_MISS = CW'(PEN_IMM + PEN_MISS_EXTRA);

    logic [CW-1:0] base_pen;
    logic [AW-1:0] rel_tgt;

    assign rel_tgt = pc + imm;

    always_comb begin
        taken    = 1'b0;
        is_call  = 1'b0;
        is_ret   = 1'b0;
        target   = '0;
        base_pen = '0;
        case (kind)
            COF_JMP_IMM: begin
                taken    = 1'b1;
                target   = imm;
                base_pen = P_IMM;
            end
            COF_JMP_REL: begin
                taken    = 1'b1;
                target   = rel_tgt;
                base_pen = P_REL;
            end
            COF_BR_COND: begin
                taken    = cond;
                target   = rel_tgt;
                base_pen = cond ? P_REL : '0;
            end
            COF_CALL: begin
                taken    = 1'b1;
                is_call  = 1'b1;
                target   = imm;
                base_pen = P_IMM;
            end
            COF_RET: begin
                taken    = 1'b1;
                is_ret   = 1'b1;
                target   = rc_valid ? rc_addr : stack_ret;
                base_pen = rc_valid ? P_IMM : P_MISS;
            end
            default: begin
                taken    = 1'b0;
            end
        endcase
        penalty = (delayed && base_pen != '0) ? base_pen - 1'b1 : base_pen;
    end

    always_comb begin
        assert (!(is_call && is_ret)); // R6
    end
endmodule

// File: rtl/cof_ret_cache.sv
module cof_ret_cache #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          clr_en,
    output logic          valid,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            addr  <= '0;
        end else if (wr_en) begin
            valid <= 1'b1;
            addr  <= wr_addr;
        end else if (clr_en) begin
            valid <= 1'b0;
        end
    end

    AST_CALL_FILLS_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid && addr == $past(wr_addr))); // R6
    AST_RET_EMPTIES_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !wr_en) |=> !valid); // R7
    AST_CACHE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr_en) |=> ($stable(valid) && $stable(addr))); // R11
endmodule

// File: rtl/cof_bubble_fsm.sv
module cof_bubble_fsm #(
    parameter int AW = 32,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] start_pen,
    input  logic [AW-1:0] start_tgt,
    input  logic          start_delayed,
    output logic          idle,
    output logic          redirect,
    output logic [AW-1:0] target,
    output logic          bubble,
    output logic          flush,
    output logic          slot_keep
);
    import cof_pkg::*;

    seq_state_e    st_q, st_n;
    logic [CW-1:0] rem_q, rem_n;
    logic [AW-1:0] tgt_q, tgt_n;
    logic          dly_q, dly_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SQ_IDLE;
            rem_q <= '0;
            tgt_q <= '0;
            dly_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            rem_q <= rem_n;
            tgt_q <= tgt_n;
            dly_q <= dly_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        rem_n = rem_q;
        tgt_n = tgt_q;
        dly_n = dly_q;
        unique case (st_q)
            SQ_IDLE: begin
                if (start && start_pen != '0) begin
                    st_n  = SQ_REDIRECT;
                    rem_n = start_pen;
                    tgt_n = start_tgt;
                    dly_n = start_delayed;
                end
            end
            SQ_REDIRECT, SQ_DRAIN: begin
                rem_n = rem_q - 1'b1;
                st_n  = (rem_q == 1) ? SQ_IDLE : SQ_DRAIN;
            end
            default: st_n = SQ_IDLE;
        endcase
    end

    always_comb begin
        idle      = (st_q == SQ_IDLE);
        redirect  = (st_q == SQ_REDIRECT);
        bubble    = (st_q != SQ_IDLE);
        flush     = bubble;
        slot_keep = redirect && dly_q;
        target    = tgt_q;
    end

    AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect); // R10
    AST_START_REDIRECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle && start_pen != '0) |=> redirect); // R10
    AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bubble && !redirect) |-> $stable(target)); // R10
    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> (rem_q != '0)); // R9
endmodule

// File: rtl/cof_sequencer.sv
module cof_sequencer #(
    parameter int AW             = 32,
    parameter int PEN_IMM        = 2,
    parameter int PEN_REL        = 3,
    parameter int PEN_MISS_EXTRA = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_valid,
    input  logic [2:0]    evt_kind,
    input  logic          evt_cond,
    input  logic          evt_delayed,
    input  logic [AW-1:0] evt_pc,
    input  logic [AW-1:0] evt_next_pc,
    input  logic [AW-1:0] evt_imm,
    input  logic [AW-1:0] stack_ret,
    output logic          fetch_redirect,
    output logic [AW-1:0] fetch_target,
    output logic          issue_bubble,
    output logic          flush_younger,
    output logic          slot_keep
);
    localparam int CW = $clog2(PEN_REL + PEN_IMM + PEN_MISS_EXTRA + 1);

    logic          idle;
    logic          taken, is_call, is_ret;
    logic [AW-1:0] tgt;
    logic [CW-1:0] pen;
    logic          rc_valid;
    logic [AW-1:0] rc_addr;
    logic          accept;

    assign accept = evt_valid && idle;

    cof_target_unit #(
        .AW(AW), .PEN_IMM(PEN_IMM), .PEN_REL(PEN_REL),
        .PEN_MISS_EXTRA(PEN_MISS_EXTRA), .CW(CW)
    ) u_target (
        .kind(evt_kind), .cond(evt_cond), .delayed(evt_delayed),
        .pc(evt_pc), .imm(evt_imm), .stack_ret(stack_ret),
        .rc_valid(rc_valid), .rc_addr(rc_addr),
        .taken(taken), .is_call(is_call), .is_ret(is_ret),
        .target(tgt), .penalty(pen)
    );

    cof_ret_cache #(.AW(AW)) u_rcache (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept && is_call), .wr_addr(evt_next_pc),
        .clr_en(accept && is_ret),
        .valid(rc_valid), .addr(rc_addr)
    );

    cof_bubble_fsm #(.AW(AW), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start(accept && taken), .start_pen(pen), .start_tgt(tgt),
        .start_delayed(evt_delayed),
        .idle(idle), .redirect(fetch_redirect), .target(fetch_target),
        .bubble(issue_bubble), .flush(flush_younger), .slot_keep(slot_keep)
    );

    AST_NOT_TAKEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && evt_kind == 3'd2 && !evt_cond) |=> !issue_bubble); // R5
    AST_UNKNOWN_KIND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && evt_kind > 3'd4) |=> !issue_bubble); // R13
    AST_SLOT_IN_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        slot_keep |-> (fetch_redirect && flush_younger)); // R9
    AST_RET_HIT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_ret && rc_valid) |=> (fetch_target == $past(rc_addr))); // R7
endmodule

// File: tb/test_cof_sequencer.sv
module test_cof_sequencer;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evt_valid = 1'b0;
    logic [2:0]    evt_kind = '0;
    logic          evt_cond = 1'b0;
    logic          evt_delayed = 1'b0;
    logic [AW-1:0] evt_pc = '0;
    logic [AW-1:0] evt_next_pc = '0;
    logic [AW-1:0] evt_imm = '0;
    logic [AW-1:0] stack_ret = '0;
    logic          fetch_redirect;
    logic [AW-1:0] fetch_target;
    logic          issue_bubble;
    logic          flush_younger;
    logic          slot_keep;

    int checks = 0;
    int errors = 0;

    bit            m_rc_v = 1'b0;
    logic [AW-1:0] m_rc_a = '0;

    always #5 clk = ~clk;

    cof_sequencer #(.AW(AW)) i_cof_sequencer (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_cond(evt_cond), .evt_delayed(evt_delayed), .evt_pc(evt_pc),
        .evt_next_pc(evt_next_pc), .evt_imm(evt_imm), .stack_ret(stack_ret),
        .fetch_redirect(fetch_redirect), .fetch_target(fetch_target),
        .issue_bubble(issue_bubble), .flush_younger(flush_younger),
        .slot_keep(slot_keep)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one event, then follow the bubble run cycle by cycle.
    // ignore_mid: also present a call event during the bubbles (R11).
    task automatic run_evt(input logic [2:0] k, input bit c, input bit d,
                           input logic [AW-1:0] pc, input logic [AW-1:0] imm,
                           input logic [AW-1:0] nxt, input logic [AW-1:0] stk,
                           input bit ignore_mid);
        bit            tk;
        int            pen;
        logic [AW-1:0] tgt;
        string         req;
        int            n;
        tk = 1'b0; pen = 0; tgt = '0; req = "R13";
        case (k)
            3'd0: begin tk = 1; pen = 2; tgt = imm; req = "R2"; end
            3'd1: begin tk = 1; pen = 3; tgt = pc + imm; req = "R3"; end
            3'd2: begin tk = c; pen = c ? 3 : 0; tgt = pc + imm; req = c ? "R4" : "R5"; end
            3'd3: begin tk = 1; pen = 2; tgt = imm; req = "R6"; end
            3'd4: begin
                tk = 1;
                if (m_rc_v) begin pen = 2; tgt = m_rc_a; req = "R7"; end
                else begin pen = 3; tgt = stk; req = "R8"; end
            end
            default: begin tk = 0; pen = 0; req = "R13"; end
        endcase
        if (tk && d) begin pen = pen - 1; req = {req, "/R9"}; end
        if (k == 3'd3) begin m_rc_v = 1'b1; m_rc_a = nxt; end
        if (k == 3'd4) m_rc_v = 1'b0;

        @(negedge clk);
        evt_valid = 1'b1; evt_kind = k; evt_cond = c; evt_delayed = d;
        evt_pc = pc; evt_imm = imm; evt_next_pc = nxt; stack_ret = stk;
        @(negedge clk);
        if (ignore_mid) begin
            evt_kind = 3'd3; evt_next_pc = 32'hDEAD_0000; evt_imm = 32'h0BAD_0000;
        end else begin
            evt_valid = 1'b0;
        end
        n = 0;
        while (issue_bubble && n < 12) begin
            chk(flush_younger == 1'b1, "R10", "flush in bubble", AW'(flush_younger), 1);
            if (n == 0) begin
                chk(fetch_redirect == 1'b1, "R10", "redirect first cycle", AW'(fetch_redirect), 1);
                chk(fetch_target == tgt, req, "target", fetch_target, tgt);
                chk(slot_keep == (d && tk), req, "slot_keep", AW'(slot_keep), AW'(d && tk));
            end else begin
                chk(fetch_redirect == 1'b0, "R10", "redirect later cycle", AW'(fetch_redirect), 0);
                chk(fetch_target == tgt, "R10", "target held", fetch_target, tgt);
                chk(slot_keep == 1'b0, "R9", "slot_keep later", AW'(slot_keep), 0);
            end
            n++;
            @(negedge clk);
            if (ignore_mid && !issue_bubble) evt_valid = 1'b0;
        end
        evt_valid = 1'b0;
        chk(n == pen, ignore_mid ? {req, "/R11"} : req, "bubble count", AW'(n), AW'(pen));
        chk(!fetch_redirect && !flush_younger, req, "quiet after run",
            AW'({fetch_redirect, flush_younger}), 0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!issue_bubble && !flush_younger && !fetch_redirect && !slot_keep, "R1",
            "outputs in reset",
            AW'({issue_bubble, flush_younger, fetch_redirect, slot_keep}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!issue_bubble && !fetch_redirect, "R1", "outputs after reset",
            AW'({issue_bubble, fetch_redirect}), 0);
        // R1/R8: the first return finds the register empty
        run_evt(3'd4, 0, 0, 32'h100, 32'h0, 32'h104, 32'h5555_0000, 0);

        // Sweep all kinds, conditions and delayed flags
        for (int k = 0; k < 8; k++)
            for (int c = 0; c < 2; c++)
                for (int d = 0; d < 2; d++)
                    run_evt(3'(k), c[0], d[0], 32'h1000 * (k + 1) + 32'h40 * c,
                            (d != 0) ? 32'hFFFF_FF00 : 32'h0000_0230 + k,
                            32'h2000_0008 + 16 * k + 4 * d, 32'h7700_0000 + 8 * k, 0);

        // R7 with R9: hit on a delayed return
        run_evt(3'd3, 0, 0, 32'h300, 32'h8000, 32'h310, 32'h0, 0);
        run_evt(3'd4, 0, 1, 32'h8010, 32'h0, 32'h8014, 32'h6666_0000, 0);
        // R12: second call overwrites the first
        run_evt(3'd3, 0, 0, 32'h400, 32'h9000, 32'h404, 32'h0, 0);
        run_evt(3'd3, 0, 1, 32'h9000, 32'hA000, 32'h9008, 32'h0, 0);
        run_evt(3'd4, 0, 0, 32'hA000, 32'h0, 32'hA004, 32'h1111_0000, 0);
        // R11: call presented during bubbles is dropped
        run_evt(3'd3, 0, 0, 32'h500, 32'hB000, 32'h504, 32'h0, 0);
        run_evt(3'd1, 0, 0, 32'hB000, 32'h20, 32'hB004, 32'h0, 1);
        run_evt(3'd4, 0, 0, 32'hB020, 32'h0, 32'hB024, 32'h2222_0000, 0);
        // R13 after a call leaves the register intact
        run_evt(3'd3, 0, 0, 32'h600, 32'hC000, 32'h604, 32'h0, 0);
        run_evt(3'd6, 1, 1, 32'hC000, 32'h10, 32'hC004, 32'h0, 0);
        run_evt(3'd4, 0, 0, 32'hC010, 32'h0, 32'hC014, 32'h3333_0000, 0);
        // R5: not-taken branch between a call and its return
        run_evt(3'd3, 0, 0, 32'h700, 32'hD000, 32'h704, 32'h0, 0);
        run_evt(3'd2, 0, 1, 32'hD000, 32'h44, 32'hD004, 32'h0, 0);
        run_evt(3'd4, 0, 1, 32'hD004, 32'h0, 32'hD008, 32'h4444_0000, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule